// File: doc/BRIEF.md
# Decimating Clock-Crossing Sample Bridge

This block sits between a sample source that produces a new word on every edge of a fast source clock and a consumer that runs on its own, unrelated destination clock. It keeps one source sample out of every `DECIM` (400 by default), parks the kept word in a holding register and announces it by inverting a single event bit. It never pulses that bit. The destination side passes the event bit through a flop synchronizer. It compares the synchronized value with its previous value, and on a change it raises a one-cycle valid strobe and captures the parked word at the same time. The multi-bit word never crosses the boundary on its own. It is only sampled once the synchronized event proves it has been stable for at least two destination edges.

The output is a stream without back-pressure. There is no ready input, so the consumer must take `dst_data` in every cycle where `dst_valid` is high. Between strobes `dst_data` holds the last delivered word. The input side has no valid flag either, because every source edge carries a sample. The bridge needs no FIFO because kept samples are far apart. `DECIM` source periods must span well over four destination periods, so the parked word is always settled before the destination reads it.

Top module: `decim_xfer_bridge`

## Requirements
- R1: `src_rst_n` and `dst_rst_n` are active-low asynchronous resets. While the destination reset is low, `dst_valid` is 0 and `dst_data` is 0. After both resets are released, no strobe appears before the first kept sample.
- R2: A source counter runs from 0 to `DECIM`-1 and then wraps to 0. The sample present on `src_data` at the source edge where the counter equals `DECIM`-1 is kept. The first kept sample is therefore the one at the `DECIM`-th source edge after reset release, and exactly one in every `DECIM` samples is forwarded.
- R3: The event bit inverts on every kept-sample edge and on no other source edge.
- R4: Each kept sample produces a `dst_valid` pulse exactly one destination cycle long. Two consecutive valid cycles never occur.
- R5: `dst_data` changes only in a cycle where `dst_valid` is high. It keeps its value in every other cycle.
- R6: Every kept sample is delivered exactly once, in the order kept, and bit-exact, including words where every bit flips from one source cycle to the next.
- R7: With two synchronizer stages, `dst_valid` and the new `dst_data` are registered on the third destination edge that follows the kept source edge. An edge that coincides with the source edge may count as the first of the three.
- R8: The holding register changes only on kept-sample edges. `DECIM` source periods must exceed four destination periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock; one sample per rising edge |
| src_rst_n | input | 1 | Asynchronous active-low reset of the source side |
| src_data | input | DATA_W | Sample stream in the source domain |
| dst_clk | input | 1 | Destination clock, unrelated to `src_clk` |
| dst_rst_n | input | 1 | Asynchronous active-low reset of the destination side |
| dst_data | output | DATA_W | Last delivered kept sample |
| dst_valid | output | 1 | One-cycle strobe marking a new `dst_data` |

## Verification
The bench builds the bridge with its default values: a 16-bit word, a 1-in-400 decimation and two synchronizer stages. The full 400-cycle counter wrap is therefore exercised on every kept sample. Across scenarios the source period is set to 1.9, 2.3 and 3.7 ns against a 4 ns destination clock, with a random sub-nanosecond phase shift. This makes the strobe latency land on both sides of a destination edge. Data patterns include a ramp, whole-word inversion on alternate cycles and random words, so a sample torn between two source values would show up as a mismatch.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Width of a counter that must hold the values 0 .. span-1.
  function automatic int unsigned count_width(input int unsigned span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

  // Fewest flop stages permitted in the event-bit synchronizer.
  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xfer_src_decim.sv
module xfer_src_decim
  import xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DECIM  = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] hold_data,
  output logic              event_tgl
);

  localparam int unsigned    CW   = count_width(DECIM);
  localparam logic [CW-1:0]  LAST = CW'(DECIM - 1);

  logic [CW-1:0] phase_cnt;
  logic          keep;

  assign keep = (phase_cnt == LAST);

  // Phase counter: 0 .. DECIM-1, wraps on the kept edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_cnt <= '0;
    else if (keep) phase_cnt <= '0;
    else           phase_cnt <= phase_cnt + 1'b1;
  end

  // Parked word and event bit move together on the kept edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      event_tgl <= 1'b0;
    end else if (keep) begin
      hold_data <= in_data;
      event_tgl <= ~event_tgl;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_cnt <= LAST);                                                   // R2
  AST_KEEP_LOADS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> hold_data == $past(in_data));                                // R2
  AST_TOGGLE_ON_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> event_tgl != $past(event_tgl));                              // R3
  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> $stable(event_tgl));                                        // R3
  AST_HOLD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> $stable(hold_data));                                        // R8

endmodule

// File: rtl/xfer_sync_chain.sv
module xfer_sync_chain
  import xfer_pkg::*;
#(
  parameter int unsigned STAGES = MIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/xfer_dst_capture.sv
module xfer_dst_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_tgl,
  input  logic [DATA_W-1:0] hold_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);

  logic prev_tgl;
  logic seen_edge;

  assign seen_edge = sync_tgl ^ prev_tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tgl  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      prev_tgl  <= sync_tgl;
      out_valid <= seen_edge;
      if (seen_edge) out_data <= hold_data;
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                            // R4
  AST_DATA_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));                                    // R5
  AST_PREV_TRACKS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> prev_tgl != $past(prev_tgl));                           // R3

endmodule

// File: rtl/decim_xfer_bridge.sv
module decim_xfer_bridge
  import xfer_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned DECIM       = 400,
  parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_valid
);

  logic [DATA_W-1:0] parked_word;
  logic              src_event;
  logic              dst_event;

  xfer_src_decim #(.DATA_W(DATA_W), .DECIM(DECIM)) u_src (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .in_data   (src_data),
    .hold_data (parked_word),
    .event_tgl (src_event)
  );

  xfer_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .async_in (src_event),
    .sync_out (dst_event)
  );

  xfer_dst_capture #(.DATA_W(DATA_W)) u_dst (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .sync_tgl  (dst_event),
    .hold_data (parked_word),
    .out_data  (dst_data),
    .out_valid (dst_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge dst_clk)
    !dst_rst_n |-> (!dst_valid && dst_data == '0));                       // R1

endmodule

// File: tb/decim_xfer_bridge_tb.sv
`timescale 1ns/1ps
module decim_xfer_bridge_tb;

  localparam int DW  = 16;
  localparam int DEC = 400;

  logic          src_clk = 1'b0, dst_clk = 1'b0;
  logic          src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic [DW-1:0] dst_data;
  logic          dst_valid;

  decim_xfer_bridge #(.DATA_W(DW), .DECIM(DEC)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_data(src_data),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_data(dst_data), .dst_valid(dst_valid)
  );

  // Clocks: 250 MHz destination, adjustable source with a phase shift.
  real src_half = 1.15;
  real skew = 0.0;
  bit  skew_pending = 1'b0;
  always #2 dst_clk = ~dst_clk;
  initial forever begin
    if (skew_pending) begin
      skew_pending = 1'b0;
      #(skew);
    end
    #(src_half) src_clk = ~src_clk;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Stimulus: new word on each falling source edge.
  int unsigned seq = 0;
  int          mode = 0;
  always @(negedge src_clk) begin
    seq++;
    case (mode)
      0:       src_data <= DW'(seq);
      1:       src_data <= seq[0] ? ~DW'(seq) : DW'(seq);
      default: src_data <= DW'($urandom);
    endcase
  end

  // Expected model from R2: count 0..DEC-1, keep on the last count.
  logic [DW-1:0] expq[$];
  real           timq[$];
  int            m_cnt = 0, kept = 0;
  always @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) m_cnt = 0;
    else if (m_cnt == DEC - 1) begin
      m_cnt = 0;
      expq.push_back(src_data);
      timq.push_back($realtime);
      kept++;
    end else m_cnt++;
  end

  // Destination monitor.
  int            rcv = 0, r5_bad = 0;
  bit            prev_v = 1'b0;
  logic [DW-1:0] last_d = '0;
  always @(negedge dst_clk) begin
    if (!dst_rst_n) begin
      prev_v = 1'b0;
      last_d = '0;
    end else begin
      if (dst_valid) begin
        rcv++;
        if (prev_v) chk(1'b0, "R4", "valid held two cycles", 2, 1);
        if (expq.size() == 0) chk(1'b0, "R6", "strobe with nothing kept", 1, 0);
        else begin
          logic [DW-1:0] e;
          real t, lat;
          e = expq.pop_front();
          t = timq.pop_front();
          lat = $realtime - t;
          chk(dst_data == e, "R6 R8", "delivered word", dst_data, e);
          chk(lat > 9.99 && lat < 14.01, "R7", "latency ps", longint'(lat * 1000.0), 12000);
        end
      end else if (dst_data != last_d) r5_bad++;
      last_d = dst_data;
      prev_v = dst_valid;
    end
  end

  task automatic do_reset(input real half, input int pat);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_half  = half;
    mode      = pat;
    skew      = real'($urandom_range(0, 997)) * 0.001;
    skew_pending = 1'b1;
    repeat (3) @(negedge dst_clk);
    chk(dst_valid == 1'b0, "R1", "valid in reset", dst_valid, 0);
    chk(dst_data == '0, "R1", "data in reset", dst_data, 0);
    expq.delete();
    timq.delete();
    rcv = 0; kept = 0; r5_bad = 0;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    @(negedge src_clk) src_rst_n = 1'b1;
  endtask

  task automatic run_stream(input real half, input int pat, input int n);
    int quiet_hits = 0;
    int guard = 0;
    do_reset(half, pat);
    repeat (100) begin
      @(negedge dst_clk);
      if (dst_valid) quiet_hits++;
    end
    chk(quiet_hits == 0, "R1", "strobes before first kept sample", quiet_hits, 0);
    while (rcv < n && guard < n * DEC * 2) begin
      @(negedge dst_clk);
      guard++;
    end
    chk(rcv >= n, "R6", "samples delivered", rcv, n);
    chk(kept - rcv >= 0 && kept - rcv <= 1, "R2 R3", "kept vs strobes", kept - rcv, 0);
    chk(r5_bad == 0, "R5", "data moved without strobe", r5_bad, 0);
  endtask

  task automatic t_ramp_fast();      run_stream(1.15, 0, 40); endtask // R2 R6 R7
  task automatic t_flip_slow();      run_stream(1.85, 1, 40); endtask // R6 R8
  task automatic t_random_faster();  run_stream(0.95, 2, 40); endtask // R6 R7
  task automatic t_reset_midstream();                                 // R1
    run_stream(1.15, 2, 5);
    repeat (57) @(negedge src_clk);
    run_stream(1.15, 0, 3);
  endtask

  initial begin
    repeat (150000) @(posedge dst_clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_ramp_fast();
    t_flip_slow();
    t_random_faster();
    t_reset_midstream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule